// File: doc/BRIEF.md
# Packet-Filter Virtual ISA Integer ALU

This block is the integer execution stage for the arithmetic and logic group of a 64-bit packet-filter virtual instruction set. Each cycle it can accept one decoded operation: a 4-bit operation code, a 3-bit instruction class, a bit that picks the second operand, the current destination and source register values, and a 32-bit immediate. One clock later it presents the value to write back to the destination register, together with a one-cycle valid strobe.

A single 64-bit datapath serves both operand widths. In the narrow class the operands are cut to 32 bits and the result is zero-extended to 64 bits. Negation and move use the same operand path as the binary operations. Negation feeds zero and the destination into the subtractor. Move passes the second operand straight through. Division and remainder are unsigned and never trap: a zero divisor gives a defined result.

Top module: `pf_int_alu`

## Requirements
- R1: While reset (rstN low) is applied and right after it, resValid is 0 and resData is 0.
- R2: resValid is high in exactly the cycle after a cycle with inValid high, and resData then holds that operation's result. Without inValid, resData keeps its previous value.
- R3: classSel 3'b111 selects 64-bit operation. Any other class value selects 32-bit operation: both operands are reduced to their low 32 bits, and the result is zero-extended, so resData[63:32] is 0.
- R4: srcSel 1 takes srcVal as the second operand. srcSel 0 takes imm32, sign-extended to 64 bits in 64-bit class.
- R5: The opcodes add 0x0, sub 0x1, mul 0x2, or 0x4, and 0x5 and xor 0xA compute dst OP operand, modulo 2^width. For mul this is the low half of the product.
- R6: The shifts are lsh 0x6 (logical left), rsh 0x7 (logical right) and arsh 0xC (arithmetic right, copying bit 63 or bit 31). The shift amount is the operand masked to 6 bits in 64-bit class and to 5 bits in 32-bit class.
- R7: div 0x3 and mod 0x9 are unsigned. A zero divisor makes div return 0 and makes mod return the destination operand unchanged, after width reduction.
- R8: neg 0x8 returns the two's-complement negation of the destination operand and ignores srcVal, imm32 and srcSel.
- R9: mov 0xB returns the selected second operand, reduced and zero-extended in 32-bit class.
- R10: The unused opcodes 0xD to 0xF return the destination operand unchanged, after width reduction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | An operation is presented this cycle |
| opCode | input | 4 | Operation code (upper nibble of the opcode byte) |
| classSel | input | 3 | Instruction class; 3'b111 selects 64-bit, any other value selects 32-bit |
| srcSel | input | 1 | 1: register operand, 0: immediate operand |
| dstVal | input | 64 | Current destination register value |
| srcVal | input | 64 | Source register value |
| imm32 | input | 32 | Immediate field |
| resValid | output | 1 | Result strobe, one cycle after inValid |
| resData | output | 64 | Value to write back to the destination register |

## Verification
The hardest cases to reach are those where masking and width reduction interact. One is a shift amount at or above the width, which must wrap and not saturate. Another is a 32-bit arithmetic right shift whose sign comes from bit 31 while bit 63 is set to the opposite value. A third is a divisor that is zero only after truncation, or only after the choice between the immediate and the register. The stimulus forces these directly. It uses shift amounts of 31, 32, 63 and 64, narrow operands with garbage in the high half, and divisors of 2^32. A long mixed run then adds bubbles, invalid classes, unused opcodes and a one-in-eight chance of a zero divisor.

// File: rtl/pf_alu_pkg.sv
package pf_alu_pkg;

  localparam int unsigned XLEN = 64;
  localparam int unsigned HLEN = 32;
  localparam int unsigned IMMW = 32;
  localparam int unsigned OPW  = 4;
  localparam int unsigned CLSW = 3;

  localparam logic [CLSW-1:0] CLS_WIDE = 3'b111;

  localparam logic [OPW-1:0] OPC_ADD  = 4'h0;
  localparam logic [OPW-1:0] OPC_SUB  = 4'h1;
  localparam logic [OPW-1:0] OPC_MUL  = 4'h2;
  localparam logic [OPW-1:0] OPC_DIV  = 4'h3;
  localparam logic [OPW-1:0] OPC_OR   = 4'h4;
  localparam logic [OPW-1:0] OPC_AND  = 4'h5;
  localparam logic [OPW-1:0] OPC_LSH  = 4'h6;
  localparam logic [OPW-1:0] OPC_RSH  = 4'h7;
  localparam logic [OPW-1:0] OPC_NEG  = 4'h8;
  localparam logic [OPW-1:0] OPC_MOD  = 4'h9;
  localparam logic [OPW-1:0] OPC_XOR  = 4'hA;
  localparam logic [OPW-1:0] OPC_MOV  = 4'hB;
  localparam logic [OPW-1:0] OPC_ARSH = 4'hC;

  typedef enum logic [3:0] {
    FN_ADD, FN_SUB, FN_MUL, FN_DIV, FN_MOD,
    FN_OR, FN_AND, FN_XOR,
    FN_SHL, FN_SHR, FN_SAR,
    FN_PASS_B, FN_PASS_A
  } aluFn_e;

  typedef struct packed {
    logic   load;
    logic   wide;
    logic   selImm;
    logic   negSwap;
    aluFn_e fn;
  } aluCtrl_t;

endpackage

// File: rtl/pf_alu_ctrl.sv
module pf_alu_ctrl
  import pf_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OPW-1:0]  opCode,
  input  logic [CLSW-1:0] classSel,
  input  logic            srcSel,
  output aluCtrl_t        ctrl,
  output logic            resValid
);

  aluFn_e fnSel;

  always_comb begin
    unique case (opCode)
      OPC_ADD:  fnSel = FN_ADD;
      OPC_SUB:  fnSel = FN_SUB;
      OPC_MUL:  fnSel = FN_MUL;
      OPC_DIV:  fnSel = FN_DIV;
      OPC_OR:   fnSel = FN_OR;
      OPC_AND:  fnSel = FN_AND;
      OPC_LSH:  fnSel = FN_SHL;
      OPC_RSH:  fnSel = FN_SHR;
      OPC_NEG:  fnSel = FN_SUB;
      OPC_MOD:  fnSel = FN_MOD;
      OPC_XOR:  fnSel = FN_XOR;
      OPC_MOV:  fnSel = FN_PASS_B;
      OPC_ARSH: fnSel = FN_SAR;
      default:  fnSel = FN_PASS_A;
    endcase
  end

  always_comb begin
    ctrl.load    = inValid;
    ctrl.wide    = (classSel == CLS_WIDE);
    ctrl.selImm  = ~srcSel;
    ctrl.negSwap = (opCode == OPC_NEG);
    ctrl.fn      = fnSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN) resValid <= 1'b0;
    else       resValid <= inValid;
  end

  // R2: strobe follows an accepted operation by exactly one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !resValid);

endmodule

// File: rtl/pf_alu_dp.sv
module pf_alu_dp
  import pf_alu_pkg::*;
#(
  parameter int unsigned DW = XLEN,
  parameter int unsigned NW = HLEN,
  parameter int unsigned IW = IMMW
) (
  input  logic          clk,
  input  logic          rstN,
  input  aluCtrl_t      ctrl,
  input  logic [DW-1:0] dstVal,
  input  logic [DW-1:0] srcVal,
  input  logic [IW-1:0] imm32,
  output logic [DW-1:0] resData
);

  localparam int unsigned SHW  = $clog2(DW);
  localparam int unsigned SHWN = $clog2(NW);

  logic [DW-1:0]   immExt;
  logic [DW-1:0]   rawA, rawB;
  logic [DW-1:0]   opA, opB;
  logic [SHW-1:0]  shAmt;
  logic [DW-1:0]   sarWide;
  logic [NW-1:0]   sarNarrow;
  logic            divZero;
  logic [DW-1:0]   fnOut;
  logic [DW-1:0]   resNext;

  assign immExt = {{(DW-IW){imm32[IW-1]}}, imm32};

  // neg reuses the subtractor: 0 - dst
  always_comb begin
    rawA = ctrl.negSwap ? '0 : dstVal;
    if (ctrl.negSwap)     rawB = dstVal;
    else if (ctrl.selImm) rawB = immExt;
    else                  rawB = srcVal;
  end

  generate
    if (DW > NW) begin : g_narrow
      always_comb begin
        opA = ctrl.wide ? rawA : {{(DW-NW){1'b0}}, rawA[NW-1:0]};
        opB = ctrl.wide ? rawB : {{(DW-NW){1'b0}}, rawB[NW-1:0]};
      end
    end else begin : g_same
      assign opA = rawA;
      assign opB = rawB;
    end
  endgenerate

  always_comb begin
    shAmt = opB[SHW-1:0];
    if (!ctrl.wide) shAmt[SHW-1:SHWN] = '0;
  end

  assign sarWide   = $signed(opA) >>> shAmt;
  assign sarNarrow = $signed(opA[NW-1:0]) >>> shAmt;
  assign divZero   = (opB == '0);

  always_comb begin
    unique case (ctrl.fn)
      FN_ADD:    fnOut = opA + opB;
      FN_SUB:    fnOut = opA - opB;
      FN_MUL:    fnOut = opA * opB;
      FN_DIV:    fnOut = divZero ? '0  : opA / opB;
      FN_MOD:    fnOut = divZero ? opA : opA % opB;
      FN_OR:     fnOut = opA | opB;
      FN_AND:    fnOut = opA & opB;
      FN_XOR:    fnOut = opA ^ opB;
      FN_SHL:    fnOut = opA << shAmt;
      FN_SHR:    fnOut = opA >> shAmt;
      FN_SAR:    fnOut = ctrl.wide ? sarWide : {{(DW-NW){1'b0}}, sarNarrow};
      FN_PASS_B: fnOut = opB;
      default:   fnOut = opA;
    endcase
  end

  assign resNext = ctrl.wide ? fnOut : {{(DW-NW){1'b0}}, fnOut[NW-1:0]};

  always_ff @(posedge clk) begin
    if (!rstN)          resData <= '0;
    else if (ctrl.load) resData <= resNext;
  end

  // R2: result is held between operations
  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> $stable(resData));
  // R3: narrow class never leaves bits in the upper half
  a_r3_zero_ext: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && !ctrl.wide) |=> (resData[DW-1:NW] == '0));
  // R7: division by zero yields zero
  a_r7_div_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.fn == FN_DIV && opB == '0) |=> (resData == '0));
  // R7: remainder by zero keeps the wide destination
  a_r7_mod_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.wide && ctrl.fn == FN_MOD && opB == '0)
      |=> (resData == $past(dstVal)));
  // R8: wide negation plus the original value sums to zero
  a_r8_neg: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && ctrl.wide && ctrl.negSwap)
      |=> ((resData + $past(dstVal)) == '0));

endmodule

// File: rtl/pf_int_alu.sv
module pf_int_alu
  import pf_alu_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            inValid,
  input  logic [OPW-1:0]  opCode,
  input  logic [CLSW-1:0] classSel,
  input  logic            srcSel,
  input  logic [XLEN-1:0] dstVal,
  input  logic [XLEN-1:0] srcVal,
  input  logic [IMMW-1:0] imm32,
  output logic            resValid,
  output logic [XLEN-1:0] resData
);

  aluCtrl_t ctrl;

  pf_alu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .opCode   (opCode),
    .classSel (classSel),
    .srcSel   (srcSel),
    .ctrl     (ctrl),
    .resValid (resValid)
  );

  pf_alu_dp #(.DW(XLEN), .NW(HLEN), .IW(IMMW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctrl    (ctrl),
    .dstVal  (dstVal),
    .srcVal  (srcVal),
    .imm32   (imm32),
    .resData (resData)
  );

endmodule

// File: tb/pf_int_alu_tb_top.sv
module pf_int_alu_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [3:0]  opCode = '0;
  logic [2:0]  classSel = '0;
  logic        srcSel = 1'b0;
  logic [63:0] dstVal = '0;
  logic [63:0] srcVal = '0;
  logic [31:0] imm32 = '0;
  logic        resValid;
  logic [63:0] resData;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  logic        expValid = 1'b0;
  logic [63:0] expData = '0;
  string       expTag = "R1";

  always #5 clk = ~clk;

  pf_int_alu dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opCode(opCode),
    .classSel(classSel), .srcSel(srcSel), .dstVal(dstVal),
    .srcVal(srcVal), .imm32(imm32), .resValid(resValid), .resData(resData)
  );

  function automatic string tagOf(input logic [3:0] op);
    case (op)
      4'h0, 4'h1, 4'h2, 4'h4, 4'h5, 4'hA: return "R5";
      4'h6, 4'h7, 4'hC: return "R6";
      4'h3, 4'h9: return "R7";
      4'h8: return "R8";
      4'hB: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [63:0] model(input logic [3:0] op, input logic [2:0] cls,
      input logic sk, input logic [63:0] d, input logic [63:0] s, input logic [31:0] im);
    bit wide;
    longint unsigned a, b, r, lo;
    int n;
    lo = 64'h0000_0000_FFFF_FFFF;
    wide = (cls == 3'b111);
    a = d;
    b = sk ? s : {{32{im[31]}}, im};
    if (!wide) begin a = a & lo; b = b & lo; end
    n = wide ? int'(b % 64) : int'(b % 32);
    case (op)
      4'h0: r = a + b;
      4'h1: r = a - b;
      4'h2: r = a * b;
      4'h3: r = (b == 0) ? 0 : a / b;
      4'h4: r = a | b;
      4'h5: r = a & b;
      4'h6: r = a << n;
      4'h7: r = a >> n;
      4'h8: r = 0 - a;
      4'h9: r = (b == 0) ? a : a % b;
      4'hA: r = a ^ b;
      4'hB: r = b;
      4'hC: begin
        if (wide) r = longint'(a) >>> n;
        else r = longint'({{32{a[31]}}, a[31:0]}) >>> n;
      end
      default: r = a;
    endcase
    if (!wide) r = r & lo;
    return r;
  endfunction

  task automatic compareNow();
    checks++;
    if (resValid !== expValid || (expValid && resData !== expData) ||
        (!expValid && resData !== expData)) begin
      errors++;
      $display("FAIL %s: valid=%0b data=%h expected valid=%0b data=%h",
               expTag, resValid, resData, expValid, expData);
    end
  endtask

  task automatic step(input bit v, input logic [3:0] op, input logic [2:0] cls,
      input logic sk, input logic [63:0] d, input logic [63:0] s, input logic [31:0] im);
    @(negedge clk);
    compareNow();
    inValid = v; opCode = op; classSel = cls; srcSel = sk;
    dstVal = d; srcVal = s; imm32 = im;
    expValid = v;
    if (v) begin
      expData = model(op, cls, sk, d, s, im);
      expTag = tagOf(op);
    end else begin
      expTag = "R2";
    end
  endtask

  task automatic idle();
    step(0, 4'hF, 3'b000, 0, 64'hDEAD_BEEF_0BAD_F00D, 64'h1234, 32'h5678);
  endtask

  localparam logic [2:0] W64 = 3'b111;
  localparam logic [2:0] W32 = 3'b100;

  initial begin
    repeat (3) begin
      @(negedge clk);
      expTag = "R1";
      compareNow();
    end
    @(negedge clk);
    rstN = 1'b1;
    expTag = "R1";
    // R1: right after reset release, outputs still at reset value
    idle();
    // R5 arithmetic, both widths and both sources
    step(1, 4'h0, W64, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 0);
    step(1, 4'h0, W32, 1, 64'hAAAA_0000_FFFF_FFFF, 64'h5555_0000_0000_0002, 0);
    step(1, 4'h1, W64, 0, 64'h10, 0, 32'hFFFF_FFFF);  // R4 sign-extended immediate
    step(1, 4'h1, W32, 0, 64'h10, 0, 32'hFFFF_FFFF);
    step(1, 4'h2, W64, 1, 64'h1_0000_0001, 64'h1_0000_0003, 0);
    step(1, 4'h2, W32, 1, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 0);
    step(1, 4'h4, W64, 0, 64'h0F00_0000_0000_0000, 64'hFFFF, 32'h8000_0000); // R4
    step(1, 4'h5, W64, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h7FFF_0000);
    step(1, 4'hA, W32, 1, 64'hFFFF_FFFF_1234_5678, 64'hFFFF_0000_FFFF_FFFF, 0);
    idle();
    idle();
    // R6 shifts and masking
    step(1, 4'h6, W64, 1, 64'h1, 64'd63, 0);
    step(1, 4'h6, W64, 1, 64'h3, 64'd64, 0);
    step(1, 4'h6, W32, 1, 64'h1, 64'd31, 0);
    step(1, 4'h6, W32, 1, 64'h5, 64'd32, 0);
    step(1, 4'h7, W64, 0, 64'h8000_0000_0000_0000, 0, 32'd63);
    step(1, 4'h7, W32, 1, 64'hFFFF_FFFF_8000_0000, 64'd33, 0);
    step(1, 4'hC, W64, 1, 64'h8000_0000_0000_0000, 64'd4, 0);
    step(1, 4'hC, W32, 1, 64'h7FFF_FFFF_8000_0000, 64'd4, 0);
    step(1, 4'hC, W32, 1, 64'h8000_0000_7000_0000, 64'd36, 0);
    // R7 division and remainder
    step(1, 4'h3, W64, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 0);
    step(1, 4'h3, W64, 1, 64'h1234, 64'h0, 0);
    step(1, 4'h3, W32, 1, 64'h1234, 64'h1_0000_0000, 0);
    step(1, 4'h9, W64, 1, 64'hDEAD_BEEF_CAFE_F00D, 64'h0, 0);
    step(1, 4'h9, W32, 1, 64'hDEAD_BEEF_CAFE_F00D, 64'h1_0000_0000, 0);
    step(1, 4'h9, W64, 0, 64'd100, 0, 32'd7);
    step(1, 4'h3, W32, 0, 64'hFFFF_FFF0, 0, 32'hFFFF_FFF0);
    // R8 neg ignores operands
    step(1, 4'h8, W64, 1, 64'h5, 64'hFFFF, 32'h1);
    step(1, 4'h8, W64, 0, 64'h5, 64'h0, 32'hFFFF_FFFF);
    step(1, 4'h8, W32, 1, 64'hFFFF_0000_0000_0001, 64'h7, 0);
    // R9 mov
    step(1, 4'hB, W64, 0, 64'h1, 64'h2, 32'h8000_0001);
    step(1, 4'hB, W32, 0, 64'h1, 64'h2, 32'h8000_0001);
    step(1, 4'hB, W32, 1, 64'h1, 64'hABCD_EF01_2345_6789, 0);
    // R10 unused opcodes, R3 odd class value
    step(1, 4'hD, W64, 1, 64'hCAFE_BABE_1234_5678, 64'h1, 0);
    step(1, 4'hF, 3'b010, 1, 64'hCAFE_BABE_1234_5678, 64'h1, 0);
    step(1, 4'h0, 3'b000, 1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 0);
    idle();
    // mixed run
    for (int i = 0; i < 3000; i++) begin
      logic [63:0] d, s;
      logic [31:0] im;
      logic [2:0] cls;
      d = {$urandom, $urandom};
      s = {$urandom, $urandom};
      im = $urandom;
      if ($urandom % 8 == 0) begin s = '0; im = '0; end
      if ($urandom % 4 == 0) s = {58'd0, s[5:0]};
      case ($urandom % 3)
        0: cls = W64;
        1: cls = W32;
        default: cls = 3'($urandom);
      endcase
      step(($urandom % 5) != 0, 4'($urandom), cls, 1'($urandom), d, s, im);
    end
    idle();
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

endmodule